// File: doc/BRIEF.md
# Shared SRAM Bank Ownership Arbiter

This block decides which of two processors, a base processor and a stack processor, owns each of a set of shared SRAM banks at any moment. Each processor has its own small register port (write strobe, word address, write data, combinational read data). Through it a processor can post requests for banks, give up banks it holds, read and acknowledge its own interrupt-cause log, and, for the base processor only, choose the sharing mode and the arbitration priority.

Two sharing schemes use the same registers. In spinlock mode each processor raises its own request bit and waits for the grant interrupt, which makes the bank a mutual-exclusion lock. In handshake mode each processor raises the other side's request bit: the base side hands a bank of data to the stack side to process, and the stack side hands it back when done. Ownership bits are set only by the arbiter and cleared only by their owner. A request against a bank held by the other side stays pending, and the holder is sent a relinquish interrupt. The base side is also flagged when it touches a bank it does not hold.

Top module: `sram_bank_owner_arb`

Register words (address: content). 0: control, bit 0 mode (1 spinlock, 0 handshake), bits 2:1 priority. 1: base-side request bits, bit b for bank b. 2: stack-side request bits, bit b for bank b. 3: log of the accessing processor. 4+b: ownership of bank b, bit 0 base, bit 1 stack. Addresses 6 and 7 read as zero.

## Requirements
- R1: After reset every register reads zero on both ports (no owner, no requests, handshake mode, equal priority, empty logs) and both interrupt lines are low.
- R2: A request for a free bank with no competing request is granted on the clock edge after the request bit is set: the requester's ownership bit becomes 1, its request bit returns to 0, and its grant log bit (base log bit 1+b, stack log bit b) is set.
- R3: Software can only clear ownership bits. Writing 1 to bit 0 of word 4+b from the base port clears the base bit, and writing 1 to bit 1 from the stack port clears the stack bit. Writing 0, or one processor writing the other's bit, has no effect.
- R4: Request bits can only be set by software. Writing 0 to a request word leaves pending requests unchanged.
- R5: When both processors request a free bank in the same cycle, priority 01 grants it to the stack side and priority 10 grants it to the base side.
- R6: Under priority 00 (or the reserved 11), ties for a bank alternate per bank, starting with the base side after reset: the loser of one tie wins the next.
- R7: A request for a bank the other side owns stays pending. On the following edge the owner's relinquish log bit (base log bit 3+b for two banks, stack log bit 2+b) is set, once per request. The grant is issued on the edge after the owner's clear takes effect, and not on the edge of the clear itself.
- R8: Word 0 changes only on a base-port write. Stack-port writes to it are ignored.
- R9: In handshake mode the base-side request bits are set from the stack port and the stack-side bits from the base port. Writes to a processor's own request word are ignored, and the highest bank's base-side request bit cannot be set at all.
- R10: A base-side SRAM access strobe naming a bank that the base side does not own sets base log bit 0 on the next edge. An access to an owned bank does not set it.
- R11: Writing 1 to a log bit clears it, and a hardware set in the same cycle wins. Each interrupt line is high exactly while its processor's log is non-zero.
- R12: A bank never has both ownership bits set, and at most one grant is issued per bank per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr | input | 1 | Base port write strobe |
| base_addr | input | ADDR_W (3) | Base port word address |
| base_wdata | input | DATA_W (8) | Base port write data |
| base_rdata | output | DATA_W (8) | Base port read data for base_addr |
| stk_wr | input | 1 | Stack port write strobe |
| stk_addr | input | ADDR_W (3) | Stack port word address |
| stk_wdata | input | DATA_W (8) | Stack port write data |
| stk_rdata | output | DATA_W (8) | Stack port read data for stk_addr |
| base_sram_acc | input | 1 | Base side is accessing SRAM this cycle |
| base_sram_bank | input | BANK_W (1) | Bank targeted by the base access |
| base_irq | output | 1 | Interrupt to the base processor |
| stk_irq | output | 1 | Interrupt to the stack processor |

## Verification
The assertions assume that each port carries at most one write per cycle and that both processors follow the ownership protocol: a processor does not request a bank it already holds, since such a request stays pending until that processor releases the bank. The stimulus keeps to this. Every request in the vector table and the directed tests is for a bank held by the other side or by nobody, and each winner releases its bank before the same bank is contended again. Write data carries no bits above the fields defined for each word.

// File: rtl/sbo_pkg.sv
package sbo_pkg;
    // processor indices inside every 2-bit per-bank vector
    localparam int PROC_BASE = 0;
    localparam int PROC_STK  = 1;

    // register word addresses; ownership words start at REG_OWN0
    localparam int REG_CTRL     = 0;
    localparam int REG_REQ_BASE = 1;
    localparam int REG_REQ_STK  = 2;
    localparam int REG_LOG      = 3;
    localparam int REG_OWN0     = 4;

    localparam logic [1:0] PRIO_EQUAL = 2'b00;
    localparam logic [1:0] PRIO_STK   = 2'b01;
    localparam logic [1:0] PRIO_BASE  = 2'b10;

    typedef struct packed {
        logic [1:0] prio;
        logic       spin;
    } ctrl_t;
endpackage

// File: rtl/sbo_port_dec.sv
module sbo_port_dec
    import sbo_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 3
) (
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    output logic                 hit_ctrl_o,
    output logic                 hit_reqb_o,
    output logic                 hit_reqs_o,
    output logic                 hit_log_o,
    output logic [NUM_BANKS-1:0] hit_own_o
);
    always_comb begin
        hit_ctrl_o = wr_i && (addr_i == ADDR_W'(REG_CTRL));
        hit_reqb_o = wr_i && (addr_i == ADDR_W'(REG_REQ_BASE));
        hit_reqs_o = wr_i && (addr_i == ADDR_W'(REG_REQ_STK));
        hit_log_o  = wr_i && (addr_i == ADDR_W'(REG_LOG));
        for (int b = 0; b < NUM_BANKS; b++) begin
            hit_own_o[b] = wr_i && (addr_i == ADDR_W'(REG_OWN0 + b));
        end
    end
endmodule

// File: rtl/sbo_bank_ctl.sv
module sbo_bank_ctl
    import sbo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] prio_i,
    input  logic [1:0] set_req_i,
    input  logic [1:0] clr_own_i,
    output logic [1:0] own_o,
    output logic [1:0] req_o,
    output logic [1:0] grant_o,
    output logic [1:0] rel_o
);
    typedef struct packed {
        logic [1:0] own;
        logic [1:0] req;
        logic [1:0] noted;   // relinquish already sent for this pending request
        logic       rr;      // 0: base wins next tie, 1: stack wins next tie
    } bank_st_t;

    bank_st_t st_q, st_d;
    logic [1:0] grant;
    logic [1:0] rel;

    always_comb begin
        st_d  = st_q;
        grant = 2'b00;
        rel   = 2'b00;

        if (st_q.own == 2'b00) begin
            if (st_q.req == 2'b11) begin
                case (prio_i)
                    PRIO_STK:  grant = 2'b10;
                    PRIO_BASE: grant = 2'b01;
                    default: begin
                        grant   = st_q.rr ? 2'b10 : 2'b01;
                        st_d.rr = ~st_q.rr;
                    end
                endcase
            end else begin
                grant = st_q.req;
            end
        end

        if (st_q.req[PROC_BASE] && st_q.own[PROC_STK] && !st_q.noted[PROC_BASE]) begin
            rel[PROC_STK]             = 1'b1;
            st_d.noted[PROC_BASE]     = 1'b1;
        end
        if (st_q.req[PROC_STK] && st_q.own[PROC_BASE] && !st_q.noted[PROC_STK]) begin
            rel[PROC_BASE]            = 1'b1;
            st_d.noted[PROC_STK]      = 1'b1;
        end

        st_d.own   = (st_q.own & ~clr_own_i) | grant;
        st_d.req   = (st_q.req & ~grant) | set_req_i;
        st_d.noted = st_d.noted & st_d.req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign own_o   = st_q.own;
    assign req_o   = st_q.req;
    assign grant_o = grant;
    assign rel_o   = rel;

    // R12: exclusive ownership and single grant
    p_own_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.own != 2'b11);
    p_grant_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    // R2: a grant lands in ownership and retires the request
    p_grant_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != 2'b00) |=> (((own_o & $past(grant_o)) == $past(grant_o)) &&
                                ((req_o & $past(grant_o) & ~$past(set_req_i)) == 2'b00)));
    // R5: fixed priorities decide ties
    p_prio_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o == 2'b00 && req_o == 2'b11 && prio_i == PRIO_BASE) |=> own_o == 2'b01);
    p_prio_stk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o == 2'b00 && req_o == 2'b11 && prio_i == PRIO_STK) |=> own_o == 2'b10);
    // R7: no grant to a waiter in the same edge the owner lets go
    p_no_early_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o[PROC_STK] && clr_own_i[PROC_STK] && req_o[PROC_BASE]) |=> own_o == 2'b00);
endmodule

// File: rtl/sbo_irq_log.sv
module sbo_irq_log #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] log_o,
    output logic         irq_o
);
    logic [W-1:0] log_d, log_q;

    always_comb begin
        log_d = (log_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    assign log_o = log_q;
    assign irq_o = |log_q;

    // R11: hardware set wins over a same-cycle clear; a lone clear empties the bit
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((log_o & $past(set_i)) == $past(set_i)));
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((log_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/sram_bank_owner_arb.sv
module sram_bank_owner_arb
    import sbo_pkg::*;
#(
    parameter int  NUM_BANKS = 2,
    parameter int  DATA_W    = 8,
    localparam int NUM_REGS  = REG_OWN0 + NUM_BANKS,
    localparam int ADDR_W    = $clog2(NUM_REGS),
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DATA_W-1:0] base_wdata,
    output logic [DATA_W-1:0] base_rdata,
    input  logic              stk_wr,
    input  logic [ADDR_W-1:0] stk_addr,
    input  logic [DATA_W-1:0] stk_wdata,
    output logic [DATA_W-1:0] stk_rdata,
    input  logic              base_sram_acc,
    input  logic [BANK_W-1:0] base_sram_bank,
    output logic              base_irq,
    output logic              stk_irq
);
    localparam int BLOG_W = 1 + 2 * NUM_BANKS;
    localparam int SLOG_W = 2 * NUM_BANKS;

    typedef struct packed {
        ctrl_t ctrl;
    } top_st_t;

    top_st_t top_q, top_d;

    logic b_ctrl, b_reqb, b_reqs, b_log;
    logic s_ctrl, s_reqb, s_reqs, s_log;
    logic [NUM_BANKS-1:0] b_own, s_own;

    logic [NUM_BANKS-1:0][1:0] own_w, req_w, grant_w, rel_w;
    logic [BLOG_W-1:0] blog, blog_set, blog_clr;
    logic [SLOG_W-1:0] slog, slog_set, slog_clr;
    logic inval;
    logic [NUM_REGS-1:0][DATA_W-1:0] view;
    logic unused_bits;

    assign unused_bits = ^{s_ctrl, base_wdata, stk_wdata};

    sbo_port_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec_base (
        .wr_i(base_wr), .addr_i(base_addr),
        .hit_ctrl_o(b_ctrl), .hit_reqb_o(b_reqb), .hit_reqs_o(b_reqs),
        .hit_log_o(b_log), .hit_own_o(b_own)
    );
    sbo_port_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec_stk (
        .wr_i(stk_wr), .addr_i(stk_addr),
        .hit_ctrl_o(s_ctrl), .hit_reqb_o(s_reqb), .hit_reqs_o(s_reqs),
        .hit_log_o(s_log), .hit_own_o(s_own)
    );

    // control word: base side only
    always_comb begin
        top_d = top_q;
        if (b_ctrl) top_d.ctrl = ctrl_t'(base_wdata[2:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [1:0] set_req;
        logic [1:0] clr_own;
        always_comb begin
            if (top_q.ctrl.spin) begin
                set_req[PROC_BASE] = b_reqb && base_wdata[b];
                set_req[PROC_STK]  = s_reqs && stk_wdata[b];
            end else begin
                set_req[PROC_BASE] = (b != NUM_BANKS - 1) && s_reqb && stk_wdata[b];
                set_req[PROC_STK]  = b_reqs && base_wdata[b];
            end
            clr_own[PROC_BASE] = b_own[b] && base_wdata[PROC_BASE];
            clr_own[PROC_STK]  = s_own[b] && stk_wdata[PROC_STK];
        end
        sbo_bank_ctl u_bank (
            .clk(clk), .rst_n(rst_n), .prio_i(top_q.ctrl.prio),
            .set_req_i(set_req), .clr_own_i(clr_own),
            .own_o(own_w[b]), .req_o(req_w[b]),
            .grant_o(grant_w[b]), .rel_o(rel_w[b])
        );
    end

    always_comb begin
        blog_set = '0;
        slog_set = '0;
        inval    = base_sram_acc;
        for (int b = 0; b < NUM_BANKS; b++) begin
            blog_set[1 + b]             = grant_w[b][PROC_BASE];
            blog_set[1 + NUM_BANKS + b] = rel_w[b][PROC_BASE];
            slog_set[b]                 = grant_w[b][PROC_STK];
            slog_set[NUM_BANKS + b]     = rel_w[b][PROC_STK];
            if (base_sram_bank == BANK_W'(b) && own_w[b][PROC_BASE]) inval = 1'b0;
        end
        blog_set[0] = inval;
        blog_clr = b_log ? base_wdata[BLOG_W-1:0] : '0;
        slog_clr = s_log ? stk_wdata[SLOG_W-1:0]  : '0;
    end

    sbo_irq_log #(.W(BLOG_W)) u_log_base (
        .clk(clk), .rst_n(rst_n), .set_i(blog_set), .clr_i(blog_clr),
        .log_o(blog), .irq_o(base_irq)
    );
    sbo_irq_log #(.W(SLOG_W)) u_log_stk (
        .clk(clk), .rst_n(rst_n), .set_i(slog_set), .clr_i(slog_clr),
        .log_o(slog), .irq_o(stk_irq)
    );

    // shared read view; the log word is per processor
    always_comb begin
        view = '0;
        view[REG_CTRL] = DATA_W'(top_q.ctrl);
        for (int b = 0; b < NUM_BANKS; b++) begin
            view[REG_REQ_BASE][b] = req_w[b][PROC_BASE];
            view[REG_REQ_STK][b]  = req_w[b][PROC_STK];
            view[REG_OWN0 + b]    = DATA_W'(own_w[b]);
        end
    end

    always_comb begin
        base_rdata = '0;
        if (int'(base_addr) == REG_LOG)      base_rdata = DATA_W'(blog);
        else if (int'(base_addr) < NUM_REGS) base_rdata = view[base_addr];
    end

    always_comb begin
        stk_rdata = '0;
        if (int'(stk_addr) == REG_LOG)      stk_rdata = DATA_W'(slog);
        else if (int'(stk_addr) < NUM_REGS) stk_rdata = view[stk_addr];
    end

    // R8: control only moves on a base write to word 0
    p_ctrl_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(base_wr && base_addr == ADDR_W'(REG_CTRL)) |=> $stable(top_q.ctrl));
    // R10: access to an unowned bank raises the invalid flag
    p_inval_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (base_sram_acc && base_sram_bank == '0 && !own_w[0][PROC_BASE]) |=> blog[0]);
endmodule

// File: tb/sim_sram_bank_owner_arb.sv
`timescale 1ns/1ps
module sim_sram_bank_owner_arb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_wr = 1'b0, stk_wr = 1'b0;
    logic [2:0] base_addr = '0, stk_addr = '0;
    logic [7:0] base_wdata = '0, stk_wdata = '0;
    logic [7:0] base_rdata, stk_rdata;
    logic       base_sram_acc = 1'b0;
    logic [0:0] base_sram_bank = '0;
    logic       base_irq, stk_irq;

    int  vecs = 0;
    int  bad  = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    sram_bank_owner_arb u0 (
        .clk(clk), .rst_n(rst_n),
        .base_wr(base_wr), .base_addr(base_addr), .base_wdata(base_wdata), .base_rdata(base_rdata),
        .stk_wr(stk_wr), .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata),
        .base_sram_acc(base_sram_acc), .base_sram_bank(base_sram_bank),
        .base_irq(base_irq), .stk_irq(stk_irq)
    );

    // who: 0 base port, 1 stack port
    typedef struct packed {
        logic       who;
        logic       wr;
        logic [2:0] addr;
        logic [7:0] data;
        logic [1:0] gap;
        logic       rwho;
        logic [2:0] raddr;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VT [NV] = '{
        '{1'b0,1'b1,3'd0,8'h01,2'd0,1'b0,3'd0,8'h01,4'd8},  // R8 base sets spinlock
        '{1'b1,1'b1,3'd0,8'h00,2'd0,1'b0,3'd0,8'h01,4'd8},  // R8 stack write ignored
        '{1'b0,1'b1,3'd1,8'h01,2'd1,1'b0,3'd4,8'h01,4'd2},  // R2 base granted bank0
        '{1'b0,1'b0,3'd0,8'h00,2'd0,1'b0,3'd1,8'h00,4'd2},  // R2 request retired
        '{1'b0,1'b0,3'd0,8'h00,2'd0,1'b0,3'd3,8'h02,4'd2},  // R2 grant logged
        '{1'b1,1'b1,3'd4,8'h03,2'd0,1'b0,3'd4,8'h01,4'd3},  // R3 foreign clear ignored
        '{1'b0,1'b1,3'd4,8'h00,2'd0,1'b0,3'd4,8'h01,4'd3},  // R3 zero write ignored
        '{1'b1,1'b1,3'd2,8'h01,2'd1,1'b0,3'd3,8'h0A,4'd7},  // R7 relinquish to base
        '{1'b0,1'b0,3'd0,8'h00,2'd0,1'b1,3'd2,8'h01,4'd7},  // R7 stack request pending
        '{1'b0,1'b1,3'd4,8'h01,2'd0,1'b1,3'd4,8'h00,4'd7},  // R7 no grant on clear edge
        '{1'b0,1'b0,3'd0,8'h00,2'd0,1'b1,3'd4,8'h02,4'd7},  // R7 grant edge after clear
        '{1'b0,1'b0,3'd0,8'h00,2'd0,1'b1,3'd3,8'h01,4'd2},  // R2 stack grant logged
        '{1'b1,1'b1,3'd3,8'h01,2'd0,1'b1,3'd3,8'h00,4'd11}, // R11 stack clears log
        '{1'b0,1'b1,3'd3,8'h0A,2'd0,1'b0,3'd3,8'h00,4'd11}, // R11 base clears log
        '{1'b0,1'b1,3'd1,8'h01,2'd0,1'b0,3'd1,8'h01,4'd4},  // R4 base request set
        '{1'b0,1'b1,3'd1,8'h00,2'd0,1'b0,3'd1,8'h01,4'd4},  // R4 zero write keeps it
        '{1'b0,1'b0,3'd0,8'h00,2'd0,1'b1,3'd3,8'h04,4'd7},  // R7 relinquish to stack
        '{1'b1,1'b1,3'd4,8'h02,2'd1,1'b0,3'd4,8'h01,4'd7},  // R7 base regains bank0
        '{1'b0,1'b0,3'd0,8'h00,2'd0,1'b0,3'd3,8'h02,4'd2},  // R2 base grant logged
        '{1'b0,1'b1,3'd3,8'h02,2'd0,1'b0,3'd3,8'h00,4'd11}, // R11
        '{1'b1,1'b1,3'd3,8'h04,2'd0,1'b1,3'd3,8'h00,4'd11}, // R11
        '{1'b0,1'b1,3'd0,8'h00,2'd0,1'b0,3'd0,8'h00,4'd8},  // R8 back to handshake
        '{1'b0,1'b1,3'd1,8'h02,2'd1,1'b0,3'd1,8'h00,4'd9},  // R9 own-word write ignored
        '{1'b1,1'b1,3'd1,8'h02,2'd1,1'b0,3'd1,8'h00,4'd9},  // R9 top bank base bit unused
        '{1'b0,1'b1,3'd2,8'h02,2'd1,1'b1,3'd5,8'h02,4'd9},  // R9 base hands bank1 to stack
        '{1'b0,1'b0,3'd0,8'h00,2'd0,1'b1,3'd2,8'h00,4'd9}   // R9 request retired
    };

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", rq, act, exp);
        end
    endtask

    task automatic step(input bit bw, input logic [2:0] ba, input logic [7:0] bd,
                        input bit sw, input logic [2:0] sa, input logic [7:0] sd);
        base_wr = bw; base_addr = ba; base_wdata = bd;
        stk_wr  = sw; stk_addr  = sa; stk_wdata  = sd;
        @(negedge clk);
        base_wr = 1'b0; stk_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chkreg(input bit who, input logic [2:0] a, input logic [7:0] exp, input string rq);
        logic [7:0] v;
        if (who) stk_addr = a; else base_addr = a;
        #1;
        v = who ? stk_rdata : base_rdata;
        chk(rq, v, exp);
    endtask

    // both sides request bank1 in the same cycle, then one edge for the grant
    task automatic tie_bank1();
        step(1'b1, 3'd1, 8'h02, 1'b1, 3'd2, 8'h02);
        idle(1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state on both ports
        for (int a = 0; a < 6; a++) begin
            chkreg(1'b0, 3'(a), 8'h00, $sformatf("R1 base word %0d", a));
            chkreg(1'b1, 3'(a), 8'h00, $sformatf("R1 stack word %0d", a));
        end
        chk("R1 base_irq", {7'd0, base_irq}, 8'h00);
        chk("R1 stk_irq", {7'd0, stk_irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [7:0] got;
            v = VT[i];
            if (v.wr) step(!v.who, v.addr, v.data, v.who, v.addr, v.data);
            else      idle(1);
            idle(int'(v.gap));
            if (v.rwho) stk_addr = v.raddr; else base_addr = v.raddr;
            #1;
            got = v.rwho ? stk_rdata : base_rdata;
            chk($sformatf("R%0d vector %0d", v.req, i), got, v.exp);
        end

        // R11 interrupt follows log contents
        chk("R11 stk_irq with grant logged", {7'd0, stk_irq}, 8'h01);
        step(1'b0, 3'd0, 8'h00, 1'b1, 3'd3, 8'h02);
        chk("R11 stk_irq after clear", {7'd0, stk_irq}, 8'h00);

        // R5 base favoured
        step(1'b1, 3'd0, 8'h05, 1'b0, 3'd0, 8'h00);
        step(1'b0, 3'd0, 8'h00, 1'b1, 3'd5, 8'h02);
        tie_bank1();
        chkreg(1'b0, 3'd5, 8'h01, "R5 R12 base favoured tie");
        step(1'b1, 3'd5, 8'h01, 1'b0, 3'd0, 8'h00);
        idle(1);
        chkreg(1'b1, 3'd5, 8'h02, "R7 loser granted after release");
        step(1'b0, 3'd0, 8'h00, 1'b1, 3'd5, 8'h02);
        step(1'b1, 3'd3, 8'h1F, 1'b1, 3'd3, 8'h0F);

        // R5 stack favoured
        step(1'b1, 3'd0, 8'h03, 1'b0, 3'd0, 8'h00);
        tie_bank1();
        chkreg(1'b0, 3'd5, 8'h02, "R5 stack favoured tie");
        step(1'b0, 3'd0, 8'h00, 1'b1, 3'd5, 8'h02);
        idle(1);
        chkreg(1'b0, 3'd5, 8'h01, "R7 base granted after stack release");
        step(1'b1, 3'd5, 8'h01, 1'b0, 3'd0, 8'h00);

        // R6 alternating ties under equal priority
        step(1'b1, 3'd0, 8'h01, 1'b0, 3'd0, 8'h00);
        tie_bank1();
        chkreg(1'b0, 3'd5, 8'h01, "R6 first tie to base");
        step(1'b1, 3'd5, 8'h01, 1'b0, 3'd0, 8'h00);
        idle(1);
        step(1'b0, 3'd0, 8'h00, 1'b1, 3'd5, 8'h02);
        tie_bank1();
        chkreg(1'b0, 3'd5, 8'h02, "R6 second tie to stack");
        step(1'b0, 3'd0, 8'h00, 1'b1, 3'd5, 8'h02);
        idle(1);
        step(1'b1, 3'd5, 8'h01, 1'b0, 3'd0, 8'h00);
        tie_bank1();
        chkreg(1'b0, 3'd5, 8'h01, "R6 third tie to base");
        step(1'b1, 3'd5, 8'h01, 1'b0, 3'd0, 8'h00);
        idle(1);
        step(1'b0, 3'd0, 8'h00, 1'b1, 3'd5, 8'h02);

        // R10 invalid access (base holds bank0, bank1 free)
        step(1'b1, 3'd3, 8'h1F, 1'b1, 3'd3, 8'h0F);
        base_sram_acc = 1'b1; base_sram_bank = 1'b0;
        @(negedge clk);
        base_sram_acc = 1'b0;
        chkreg(1'b0, 3'd3, 8'h00, "R10 owned bank access");
        base_sram_acc = 1'b1; base_sram_bank = 1'b1;
        @(negedge clk);
        base_sram_acc = 1'b0;
        chkreg(1'b0, 3'd3, 8'h01, "R10 unowned bank access");
        chk("R11 base_irq on invalid flag", {7'd0, base_irq}, 8'h01);

        // R11 set beats same-cycle clear
        base_sram_acc = 1'b1; base_sram_bank = 1'b1;
        step(1'b1, 3'd3, 8'h01, 1'b0, 3'd0, 8'h00);
        base_sram_acc = 1'b0;
        chkreg(1'b0, 3'd3, 8'h01, "R11 set wins over clear");
        step(1'b1, 3'd3, 8'h01, 1'b0, 3'd0, 8'h00);
        chkreg(1'b0, 3'd3, 8'h00, "R11 plain clear");
        chk("R11 base_irq low", {7'd0, base_irq}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end
endmodule